// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds a small bank of one-bit ownership flags shared by two independent ports, called left and right, that sit on either side of a shared memory. Software on each side uses a flag to claim a region of that memory before touching it. A side asks for a flag by writing 0 to it and gives it back by writing 1. Reading a flag tells that side whether it is the current owner. A request made while the other side owns the flag is remembered. When the owner lets go, the flag moves straight to the waiting side, so no retry loop is needed to catch the release.

Each port carries a flag-bank select, a memory select, a write strobe, an output enable, a flag index and a single write bit, all active-low where named `_n`. A flag access counts only when the flag-bank select is low and the memory select is high. The bank runs on one clock. Writes take effect at the clock edge that samples them. Read data is registered and appears one cycle after the read access. It shows the ownership state as it stood before that edge's updates. The ports are plain control pins with no valid/ready handshake: every sampled access completes in its cycle, so no back-pressure exists.

Top module: `sem_bank`

## Requirements
- R1: An access is valid only when `x_sel_n`=0 and `x_mem_sel_n`=1. With `x_sel_n`=1, or with both selects low, no flag changes, and the next-cycle read data is all ones.
- R2: `x_idx` selects one of NUM_SEM flags. A valid access changes and reports only the indexed flag.
- R3: A valid write (`x_wr_n`=0) with `x_wbit`=0 to a free flag makes the writing port its owner from the next cycle.
- R4: A valid write of 0 from a port while the other port owns the flag records a pending request for the writer. A write of 0 from the current owner changes nothing.
- R5: A valid write of 1 from the owner releases the flag. If the other port has a pending request, ownership passes to it at that same edge and its request clears. Otherwise the flag becomes free.
- R6: A valid write of 1 from a port that does not own the flag withdraws that port's pending request, if it has one.
- R7: When both ports act on the same flag in one cycle, the left operation is applied first and the right operation is then applied to the result. Both requesting a free flag therefore grants left and leaves right pending. A left release together with a right request hands the flag to right.
- R8: A valid read (`x_wr_n`=1, `x_out_en_n`=0) drives `x_rdata` one cycle later. Bit 0 is 0 if the reading port owned the flag at the read edge and 1 otherwise. All bits above bit 0 read 1.
- R9: In a cycle without a valid read (output enable high, a write, deselected or invalid), `x_rdata` is all ones in the following cycle.
- R10: After reset all flags are free, no requests are pending, and both read buses are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left flag-bank select, active low |
| l_mem_sel_n | input | 1 | Left memory select, active low; must be high for a flag access |
| l_wr_n | input | 1 | Left write strobe, active low (high = read) |
| l_out_en_n | input | 1 | Left output enable, active low |
| l_idx | input | ADDR_W | Left flag index |
| l_wbit | input | 1 | Left write value: 0 requests, 1 releases |
| l_rdata | output | DATA_W | Left read data, registered |
| r_sel_n | input | 1 | Right flag-bank select, active low |
| r_mem_sel_n | input | 1 | Right memory select, active low; must be high for a flag access |
| r_wr_n | input | 1 | Right write strobe, active low (high = read) |
| r_out_en_n | input | 1 | Right output enable, active low |
| r_idx | input | ADDR_W | Right flag index |
| r_wbit | input | 1 | Right write value: 0 requests, 1 releases |
| r_rdata | output | DATA_W | Right read data, registered |

## Verification
A wrong owner field shows on bit 0 of the first read of that flag from either side, one cycle after the read access. A wrong pending bit stays hidden until the owner releases: ownership then goes to the wrong side or to neither. For that reason the directed tests always follow a release with reads from both ports. Same-cycle collisions are driven on one flag to pin down the left-first ordering, and invalid select combinations are each followed by a valid read to show that nothing changed.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } sem_owner_e;

  typedef struct packed {
    sem_owner_e own;
    logic       pend_l;
    logic       pend_r;
  } sem_flag_t;

  localparam sem_flag_t SEM_FLAG_RST = '{own: SEM_FREE, pend_l: 1'b0, pend_r: 1'b0};

  // Apply one port's request/release to a flag state.
  function automatic sem_flag_t sem_apply(input sem_flag_t s, input logic is_left,
                                          input logic req, input logic rel);
    sem_flag_t  n;
    sem_owner_e me;
    sem_owner_e other;
    logic       other_pend;
    n          = s;
    me         = is_left ? SEM_LEFT : SEM_RIGHT;
    other      = is_left ? SEM_RIGHT : SEM_LEFT;
    other_pend = is_left ? s.pend_r : s.pend_l;
    if (req) begin
      if (s.own == SEM_FREE) begin
        n.own = me;
      end else if (s.own != me) begin
        if (is_left) n.pend_l = 1'b1;
        else         n.pend_r = 1'b1;
      end
    end
    if (rel) begin
      if (s.own == me) begin
        if (other_pend) begin
          n.own = other;
          if (is_left) n.pend_r = 1'b0;
          else         n.pend_l = 1'b0;
        end else begin
          n.own = SEM_FREE;
        end
      end else begin
        if (is_left) n.pend_l = 1'b0;
        else         n.pend_r = 1'b0;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic              sel_n,
  input  logic              mem_sel_n,
  input  logic              wr_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] idx,
  input  logic              wbit,
  output logic [NUM_SEM-1:0] req,
  output logic [NUM_SEM-1:0] rel,
  output logic              rd_en
);
  logic acc_ok;
  logic wr_en;

  assign acc_ok = ~sel_n & mem_sel_n;
  assign wr_en  = acc_ok & ~wr_n;
  assign rd_en  = acc_ok & wr_n & ~out_en_n;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_hit
    logic hit;
    assign hit    = wr_en & (idx == ADDR_W'(i));
    assign req[i] = hit & ~wbit;
    assign rel[i] = hit & wbit;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic held_l,
  output logic held_r,
  output logic pend_l,
  output logic pend_r
);
  sem_flag_t st_q;
  sem_flag_t after_l;
  sem_flag_t st_d;

  always_comb begin
    after_l = sem_apply(st_q, 1'b1, req_l, rel_l);
    st_d    = sem_apply(after_l, 1'b0, req_r, rel_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEM_FLAG_RST;
    else        st_q <= st_d;
  end

  assign held_l = (st_q.own == SEM_LEFT);
  assign held_r = (st_q.own == SEM_RIGHT);
  assign pend_l = st_q.pend_l;
  assign pend_r = st_q.pend_r;
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  idx,
  input  logic [NUM_SEM-1:0] held,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '1;
    if (rd_en) rdata_d[0] = ~held[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '1;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_mem_sel_n,
  input  logic              l_wr_n,
  input  logic              l_out_en_n,
  input  logic [ADDR_W-1:0] l_idx,
  input  logic              l_wbit,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel_n,
  input  logic              r_mem_sel_n,
  input  logic              r_wr_n,
  input  logic              r_out_en_n,
  input  logic [ADDR_W-1:0] r_idx,
  input  logic              r_wbit,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r;
  logic [NUM_SEM-1:0] held_l, held_r, pend_l, pend_r;
  logic               rd_en_l, rd_en_r;

  sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_l (
    .sel_n(l_sel_n), .mem_sel_n(l_mem_sel_n), .wr_n(l_wr_n), .out_en_n(l_out_en_n),
    .idx(l_idx), .wbit(l_wbit), .req(req_l), .rel(rel_l), .rd_en(rd_en_l)
  );

  sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_r (
    .sel_n(r_sel_n), .mem_sel_n(r_mem_sel_n), .wr_n(r_wr_n), .out_en_n(r_out_en_n),
    .idx(r_idx), .wbit(r_wbit), .req(req_r), .rel(rel_r), .rd_en(rd_en_r)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(req_l[i]), .rel_l(rel_l[i]), .req_r(req_r[i]), .rel_r(rel_r[i]),
      .held_l(held_l[i]), .held_r(held_r[i]), .pend_l(pend_l[i]), .pend_r(pend_r[i])
    );
  end

  sem_readback #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rb_l (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en_l), .idx(l_idx), .held(held_l), .rdata(l_rdata)
  );

  sem_readback #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rb_r (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en_r), .idx(r_idx), .held(held_r), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(NUM_SEM)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_sel_n,
  input logic               l_mem_sel_n,
  input logic               l_wr_n,
  input logic [ADDR_W-1:0]  l_idx,
  input logic               l_wbit,
  input logic [DATA_W-1:0]  l_rdata,
  input logic               r_sel_n,
  input logic               r_mem_sel_n,
  input logic               r_wr_n,
  input logic [ADDR_W-1:0]  r_idx,
  input logic [DATA_W-1:0]  r_rdata,
  input logic [NUM_SEM-1:0] held_l,
  input logic [NUM_SEM-1:0] held_r,
  input logic [NUM_SEM-1:0] pend_l,
  input logic [NUM_SEM-1:0] pend_r
);
  logic l_ok, r_ok, l_bad;
  assign l_ok  = ~l_sel_n & l_mem_sel_n;
  assign r_ok  = ~r_sel_n & r_mem_sel_n;
  assign l_bad = ~l_sel_n & ~l_mem_sel_n;

  // R8
  upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&l_rdata[DATA_W-1:1]) && (&r_rdata[DATA_W-1:1]));

  // R1
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_bad |=> (l_rdata == '1));

  // R4
  pend_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_l & ~held_r) == '0) && ((pend_r & ~held_l) == '0));

  // R3
  left_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ok && !l_wr_n && !l_wbit && !held_l[l_idx] && !held_r[l_idx])
    |=> held_l[$past(l_idx)]);

  // R5
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ok && !l_wr_n && l_wbit && held_l[l_idx] && pend_r[l_idx]
     && !(r_ok && !r_wr_n && r_idx == l_idx))
    |=> (held_r[$past(l_idx)] && !pend_r[$past(l_idx)]));
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel_n(l_sel_n), .l_mem_sel_n(l_mem_sel_n), .l_wr_n(l_wr_n), .l_idx(l_idx),
  .l_wbit(l_wbit), .l_rdata(l_rdata),
  .r_sel_n(r_sel_n), .r_mem_sel_n(r_mem_sel_n), .r_wr_n(r_wr_n), .r_idx(r_idx),
  .r_rdata(r_rdata),
  .held_l(held_l), .held_r(held_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
  localparam int NUM_SEM = 8;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = $clog2(NUM_SEM);
  localparam logic [DATA_W-1:0] OWNED = 16'hFFFE;
  localparam logic [DATA_W-1:0] NOT_OWNED = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel_n = 1'b1, l_mem_sel_n = 1'b1, l_wr_n = 1'b1, l_out_en_n = 1'b1, l_wbit = 1'b1;
  logic r_sel_n = 1'b1, r_mem_sel_n = 1'b1, r_wr_n = 1'b1, r_out_en_n = 1'b1, r_wbit = 1'b1;
  logic [ADDR_W-1:0] l_idx = '0, r_idx = '0;
  logic [DATA_W-1:0] l_rdata, r_rdata;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sem_bank #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_sem_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_mem_sel_n(l_mem_sel_n), .l_wr_n(l_wr_n), .l_out_en_n(l_out_en_n),
    .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_mem_sel_n(r_mem_sel_n), .r_wr_n(r_wr_n), .r_out_en_n(r_out_en_n),
    .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input bit lft, input logic sel, input logic mem, input logic wr,
                     input logic oe, input int idx, input logic b);
    if (lft) begin
      l_sel_n = sel; l_mem_sel_n = mem; l_wr_n = wr; l_out_en_n = oe;
      l_idx = ADDR_W'(idx); l_wbit = b;
    end else begin
      r_sel_n = sel; r_mem_sel_n = mem; r_wr_n = wr; r_out_en_n = oe;
      r_idx = ADDR_W'(idx); r_wbit = b;
    end
  endtask

  task automatic idle();
    put(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1);
    put(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1);
  endtask

  task automatic wr(input bit lft, input int idx, input logic b);
    put(lft, 1'b0, 1'b1, 1'b0, 1'b1, idx, b);
    tick();
    idle();
  endtask

  task automatic rd(input bit lft, input int idx, input logic [DATA_W-1:0] exp, input string tag);
    put(lft, 1'b0, 1'b1, 1'b1, 1'b0, idx, 1'b1);
    tick();
    chk(tag, lft ? l_rdata : r_rdata, exp);
    idle();
  endtask

  task automatic t_reset();
    chk("R10 left bus after reset", l_rdata, NOT_OWNED);
    chk("R10 right bus after reset", r_rdata, NOT_OWNED);
    for (int i = 0; i < NUM_SEM; i++) begin
      rd(1'b1, i, NOT_OWNED, "R10 left flag free");
      rd(1'b0, i, NOT_OWNED, "R10 right flag free");
    end
  endtask

  task automatic t_grant();
    wr(1'b1, 2, 1'b0);
    rd(1'b1, 2, OWNED, "R3 left owns flag 2");
    rd(1'b0, 2, NOT_OWNED, "R8 right sees not owner");
    rd(1'b1, 3, NOT_OWNED, "R2 neighbour flag 3 untouched");
    rd(1'b1, 1, NOT_OWNED, "R2 neighbour flag 1 untouched");
  endtask

  task automatic t_handoff();
    wr(1'b0, 2, 1'b0);
    rd(1'b0, 2, NOT_OWNED, "R4 right request only pending");
    rd(1'b1, 2, OWNED, "R4 left still owner");
    wr(1'b1, 2, 1'b1);
    rd(1'b0, 2, OWNED, "R5 flag handed to right");
    rd(1'b1, 2, NOT_OWNED, "R5 left no longer owner");
    wr(1'b0, 2, 1'b1);
    rd(1'b0, 2, NOT_OWNED, "R5 right release frees");
    wr(1'b1, 2, 1'b0);
    rd(1'b1, 2, OWNED, "R5 freed flag regranted to left");
    wr(1'b1, 2, 1'b1);
    rd(1'b1, 2, NOT_OWNED, "R5 left release no waiter");
    rd(1'b0, 2, NOT_OWNED, "R5 right not granted without request");
  endtask

  task automatic t_withdraw();
    wr(1'b1, 5, 1'b0);
    wr(1'b0, 5, 1'b0);
    wr(1'b0, 5, 1'b1);
    rd(1'b1, 5, OWNED, "R6 withdraw leaves owner intact");
    wr(1'b1, 5, 1'b1);
    rd(1'b0, 5, NOT_OWNED, "R6 withdrawn request not granted");
    rd(1'b1, 5, NOT_OWNED, "R6 flag free after release");
  endtask

  task automatic t_collide();
    put(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b0);
    put(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b0);
    tick();
    idle();
    rd(1'b1, 1, OWNED, "R7 left wins tie");
    rd(1'b0, 1, NOT_OWNED, "R7 right loses tie");
    wr(1'b1, 1, 1'b1);
    rd(1'b0, 1, OWNED, "R7 right tie request kept pending");
    put(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6, 1'b0);
    tick();
    idle();
    put(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6, 1'b1);
    put(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6, 1'b0);
    tick();
    idle();
    rd(1'b0, 6, OWNED, "R7 left release then right request");
    rd(1'b1, 6, NOT_OWNED, "R7 left gave up flag 6");
    wr(1'b0, 1, 1'b1);
    wr(1'b0, 6, 1'b1);
  endtask

  task automatic t_invalid();
    put(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4, 1'b0);
    tick();
    chk("R1 invalid write read bus", l_rdata, NOT_OWNED);
    idle();
    rd(1'b1, 4, NOT_OWNED, "R1 invalid write ignored");
    put(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4, 1'b0);
    tick();
    idle();
    rd(1'b1, 4, NOT_OWNED, "R1 deselected write ignored");
    wr(1'b1, 4, 1'b0);
    put(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4, 1'b1);
    tick();
    chk("R1 invalid read returns ones", l_rdata, NOT_OWNED);
    idle();
    put(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4, 1'b1);
    tick();
    chk("R9 output enable high", l_rdata, NOT_OWNED);
    idle();
    wr(1'b1, 4, 1'b0);
    rd(1'b1, 4, OWNED, "R4 owner rerequest no change");
    tick();
    chk("R9 bus idles to ones", l_rdata, NOT_OWNED);
    wr(1'b1, 4, 1'b1);
    rd(1'b1, 4, NOT_OWNED, "R5 released flag 4");
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_grant();
    t_handoff();
    t_withdraw();
    t_collide();
    t_invalid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule